// File: doc/BRIEF.md
# Poison-Tracking Register File for Deferred Speculative Faults

This block is an architectural register file in which every entry carries two status flags beside its data: a poison flag and a flag recording whether the most recent writer was speculative. It lets a compiler hoist instructions above branches. A fatal fault raised by a hoisted instruction is not reported when it happens. It is parked as poison on the destination register and reported only if a non-speculative instruction later consumes that register. A fault that can be resumed is still reported at once, whichever instruction caused it.

The file has two combinational read ports and one write port. A read is qualified by `rd_valid` and by `rd_spec`, which tells the block whether the consuming instruction is speculative. The write port carries the writer's speculative flag, its fault class and the poison flag of its sources (`wr_src_poison`). The pipeline feeds this last input back from `src_poison`, so poison travels along dependent speculative chains. A separate control port sets or clears a poison flag on request. At most one exception is reported per cycle. It appears in the cycle after its cause and carries a cause code and a register number. A two-state reporter (`EXS_IDLE`, `EXS_RAISE`) drives it. The reporter moves from EXS_IDLE to EXS_RAISE on any fault event and stays there while events keep coming. It returns to EXS_IDLE in the first cycle with no event.

Top module: `poison_regfile`

## Requirements
- R1: After reset every register reads data 0 with the poison flag and the speculative flag clear, and `exc_req` is low.
- R2: Register 0 always reads data 0 with both flags clear. Writes and control operations aimed at it have no effect on it.
- R3: A write with `wr_exc`=0 (no fault) to register r≠0 stores `wr_data` and sets the speculative flag to `wr_spec`. It sets poison to `wr_spec & wr_src_poison`. Each read port returns the addressed entry's data, poison flag and speculative flag in the same cycle. The new value is seen from the next cycle on.
- R4: A speculative write with a terminating fault (`wr_exc`=2, or 3, which is treated as 2) raises no exception. It stores `wr_data`, sets the speculative flag and sets poison.
- R5: A write with a resumable fault (`wr_exc`=1) raises `exc_req` in the next cycle with `exc_cause`=1 and `exc_reg`=`wr_idx`, speculative or not. The register is left unchanged.
- R6: A non-speculative write with a terminating fault raises `exc_cause`=2 with `exc_reg`=`wr_idx` in the next cycle. The register is left unchanged.
- R7: A valid non-speculative read (`rd_valid`=1, `rd_spec`=0) of a poisoned source raises `exc_cause`=3 in the next cycle. `exc_reg` names that source. If both sources are poisoned, one exception is reported and it names the lower register number.
- R8: A speculative read of poisoned sources raises no exception. `src_poison` is the OR of the two ports' poison flags.
- R9: `ctl_op`=1 sets and `ctl_op`=2 clears the poison flag of `ctl_idx`. Codes 0 and 3 do nothing. A control operation leaves the speculative flag alone. It overrides the poison value of a write to the same register in the same cycle.
- R10: When a write fault (R5, R6) and a poisoned read (R7) occur in the same cycle, only the write fault is reported. When `exc_req` is low, `exc_cause` and `exc_reg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | An instruction consumes the two read ports this cycle |
| rd_spec | input | 1 | The consuming instruction is speculative |
| rd_a_idx | input | IDX_W | Read port A register number |
| rd_b_idx | input | IDX_W | Read port B register number |
| rd_a_data | output | DATA_W | Port A data |
| rd_a_poison | output | 1 | Port A poison flag |
| rd_a_spec | output | 1 | Port A speculative-writer flag |
| rd_b_data | output | DATA_W | Port B data |
| rd_b_poison | output | 1 | Port B poison flag |
| rd_b_spec | output | 1 | Port B speculative-writer flag |
| src_poison | output | 1 | OR of both ports' poison flags |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Destination register |
| wr_data | input | DATA_W | Write data |
| wr_spec | input | 1 | Writer is speculative |
| wr_exc | input | 2 | Writer fault class: 0 none, 1 resumable, 2/3 terminating |
| wr_src_poison | input | 1 | Writer consumed a poisoned source |
| ctl_op | input | 2 | 0 nop, 1 set poison, 2 clear poison, 3 nop |
| ctl_idx | input | IDX_W | Target of the control operation |
| exc_req | output | 1 | Exception request, one cycle after its cause |
| exc_cause | output | 2 | 0 none, 1 resumable, 2 terminating, 3 poison consumed |
| exc_reg | output | IDX_W | Register tied to the exception |

## Verification
The hardest case to reach is a double-poisoned non-speculative read that wins the exception slot. It needs two distinct registers poisoned beforehand, a read naming both in either port order, and no faulting write in the same cycle. Any one of these is rare under plain random traffic. The bench first poisons registers through speculative terminating writes and through the control port. It then issues directed reads with the higher-numbered register on port A and on port B, and repeats one of them with a competing resumable write to exercise priority. Random traffic biased toward a small set of registers keeps poison propagation through `wr_src_poison` occurring often.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_RESUME = 2'd1,
        FLT_FATAL  = 2'd2,
        FLT_FATAL2 = 2'd3
    } fault_class_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_RESUME = 2'd1,
        CAUSE_FATAL  = 2'd2,
        CAUSE_POISON = 2'd3
    } exc_cause_e;

    typedef enum logic [1:0] {
        CTL_NOP   = 2'd0,
        CTL_SET   = 2'd1,
        CTL_CLR   = 2'd2,
        CTL_NOP_B = 2'd3
    } flag_ctl_e;

    typedef enum logic {
        EXS_IDLE  = 1'b0,
        EXS_RAISE = 1'b1
    } exc_state_e;

endpackage

// File: rtl/prf_storage.sv
module prf_storage
    import poison_rf_pkg::*;
#(
    parameter int NREGS  = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit_en,
    input  logic [IDX_W-1:0]              commit_idx,
    input  logic [DATA_W-1:0]             commit_data,
    input  logic                          commit_spec,
    input  logic                          commit_poison,
    input  logic [1:0]                    ctl_op,
    input  logic [IDX_W-1:0]              ctl_idx,
    output logic [NREGS-1:0][DATA_W-1:0]  data_arr,
    output logic [NREGS-1:0]              poison_arr,
    output logic [NREGS-1:0]              spec_arr
);

    flag_ctl_e ctl;
    assign ctl = flag_ctl_e'(ctl_op);

    // entry 0 is hard-wired
    assign data_arr[0]   = '0;
    assign poison_arr[0] = 1'b0;
    assign spec_arr[0]   = 1'b0;

    for (genvar r = 1; r < NREGS; r++) begin : g_entry
        logic hit_wr, hit_ctl;
        assign hit_wr  = commit_en && (commit_idx == IDX_W'(r));
        assign hit_ctl = (ctl_idx == IDX_W'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_arr[r]   <= '0;
                poison_arr[r] <= 1'b0;
                spec_arr[r]   <= 1'b0;
            end else begin
                if (hit_wr) begin
                    data_arr[r] <= commit_data;
                    spec_arr[r] <= commit_spec;
                end
                if (hit_ctl && ctl == CTL_SET) begin
                    poison_arr[r] <= 1'b1;
                end else if (hit_ctl && ctl == CTL_CLR) begin
                    poison_arr[r] <= 1'b0;
                end else if (hit_wr) begin
                    poison_arr[r] <= commit_poison;
                end
            end
        end
    end

endmodule

// File: rtl/prf_rd_port.sv
module prf_rd_port #(
    parameter int NREGS  = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [IDX_W-1:0]              idx,
    input  logic [NREGS-1:0][DATA_W-1:0]  data_arr,
    input  logic [NREGS-1:0]              poison_arr,
    input  logic [NREGS-1:0]              spec_arr,
    output logic [DATA_W-1:0]             data,
    output logic                          poison,
    output logic                          spec
);

    always_comb begin
        data   = data_arr[idx];
        poison = poison_arr[idx];
        spec   = spec_arr[idx];
    end

endmodule

// File: rtl/prf_exc_ctrl.sv
module prf_exc_ctrl
    import poison_rf_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_spec,
    input  logic [1:0]       wr_exc,
    input  logic             rd_valid,
    input  logic             rd_spec,
    input  logic [IDX_W-1:0] a_idx,
    input  logic             a_poison,
    input  logic [IDX_W-1:0] b_idx,
    input  logic             b_poison,
    output logic             wr_commit,
    output logic             wr_fatal,
    output logic             exc_req,
    output logic [1:0]       exc_cause,
    output logic [IDX_W-1:0] exc_reg
);

    fault_class_e flt;
    exc_state_e   state_q, state_d;
    exc_cause_e   cause_d, cause_q;
    logic [IDX_W-1:0] reg_d, reg_q;
    logic             wr_raise, rd_raise, evt;

    assign flt       = fault_class_e'(wr_exc);
    assign wr_fatal  = (flt == FLT_FATAL) || (flt == FLT_FATAL2);
    assign wr_raise  = wr_en && ((flt == FLT_RESUME) || (wr_fatal && !wr_spec));
    assign wr_commit = wr_en && !wr_raise;
    assign rd_raise  = rd_valid && !rd_spec && (a_poison || b_poison);
    assign evt       = wr_raise || rd_raise;

    // event selection: write fault outranks poison consumption
    always_comb begin
        cause_d = CAUSE_NONE;
        reg_d   = '0;
        if (wr_raise) begin
            cause_d = (flt == FLT_RESUME) ? CAUSE_RESUME : CAUSE_FATAL;
            reg_d   = wr_idx;
        end else if (rd_raise) begin
            cause_d = CAUSE_POISON;
            if (a_poison && b_poison) begin
                reg_d = (a_idx < b_idx) ? a_idx : b_idx;
            end else if (a_poison) begin
                reg_d = a_idx;
            end else begin
                reg_d = b_idx;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXS_IDLE:  state_d = evt ? EXS_RAISE : EXS_IDLE;
            EXS_RAISE: state_d = evt ? EXS_RAISE : EXS_IDLE;
            default:   state_d = EXS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EXS_IDLE;
            cause_q <= CAUSE_NONE;
            reg_q   <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            reg_q   <= reg_d;
        end
    end

    always_comb begin
        exc_req   = 1'b0;
        exc_cause = CAUSE_NONE;
        exc_reg   = '0;
        unique case (state_q)
            EXS_IDLE: begin
                exc_req = 1'b0;
            end
            EXS_RAISE: begin
                exc_req   = 1'b1;
                exc_cause = cause_q;
                exc_reg   = reg_q;
            end
            default: begin
                exc_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
    import poison_rf_pkg::*;
#(
    parameter int NREGS  = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic              rd_spec,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_poison,
    output logic              rd_a_spec,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_poison,
    output logic              rd_b_spec,
    output logic              src_poison,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_spec,
    input  logic [1:0]        wr_exc,
    input  logic              wr_src_poison,
    input  logic [1:0]        ctl_op,
    input  logic [IDX_W-1:0]  ctl_idx,
    output logic              exc_req,
    output logic [1:0]        exc_cause,
    output logic [IDX_W-1:0]  exc_reg
);

    localparam int NPORTS = 2;

    logic [NREGS-1:0][DATA_W-1:0] data_arr;
    logic [NREGS-1:0]             poison_arr, spec_arr;
    logic                         wr_commit, wr_fatal, commit_poison;

    logic [NPORTS-1:0][IDX_W-1:0]  p_idx;
    logic [NPORTS-1:0][DATA_W-1:0] p_data;
    logic [NPORTS-1:0]             p_poison, p_spec;

    assign p_idx[0] = rd_a_idx;
    assign p_idx[1] = rd_b_idx;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        prf_rd_port #(.NREGS(NREGS), .DATA_W(DATA_W)) port_i (
            .idx        (p_idx[p]),
            .data_arr   (data_arr),
            .poison_arr (poison_arr),
            .spec_arr   (spec_arr),
            .data       (p_data[p]),
            .poison     (p_poison[p]),
            .spec       (p_spec[p])
        );
    end

    assign rd_a_data   = p_data[0];
    assign rd_a_poison = p_poison[0];
    assign rd_a_spec   = p_spec[0];
    assign rd_b_data   = p_data[1];
    assign rd_b_poison = p_poison[1];
    assign rd_b_spec   = p_spec[1];
    assign src_poison  = |p_poison;

    // a speculative writer parks its fatal fault or inherited poison
    assign commit_poison = wr_spec && (wr_fatal || wr_src_poison);

    prf_exc_ctrl #(.NREGS(NREGS)) exc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_spec   (wr_spec),
        .wr_exc    (wr_exc),
        .rd_valid  (rd_valid),
        .rd_spec   (rd_spec),
        .a_idx     (rd_a_idx),
        .a_poison  (p_poison[0]),
        .b_idx     (rd_b_idx),
        .b_poison  (p_poison[1]),
        .wr_commit (wr_commit),
        .wr_fatal  (wr_fatal),
        .exc_req   (exc_req),
        .exc_cause (exc_cause),
        .exc_reg   (exc_reg)
    );

    prf_storage #(.NREGS(NREGS), .DATA_W(DATA_W)) store_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_en     (wr_commit),
        .commit_idx    (wr_idx),
        .commit_data   (wr_data),
        .commit_spec   (wr_spec),
        .commit_poison (commit_poison),
        .ctl_op        (ctl_op),
        .ctl_idx       (ctl_idx),
        .data_arr      (data_arr),
        .poison_arr    (poison_arr),
        .spec_arr      (spec_arr)
    );

endmodule

// File: rtl/poison_regfile_chk.sv
module poison_regfile_chk #(
    parameter int NREGS  = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              rd_spec,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [IDX_W-1:0]  rd_b_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              rd_a_poison,
    input logic              rd_a_spec,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              rd_b_poison,
    input logic              rd_b_spec,
    input logic              src_poison,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_spec,
    input logic [1:0]        wr_exc,
    input logic              wr_src_poison,
    input logic [1:0]        ctl_op,
    input logic [IDX_W-1:0]  ctl_idx,
    input logic              exc_req,
    input logic [1:0]        exc_cause,
    input logic [IDX_W-1:0]  exc_reg
);

    logic wr_raise, rd_raise, past_ok;
    assign wr_raise = wr_en && ((wr_exc == 2'd1) || (wr_exc[1] && !wr_spec));
    assign rd_raise = rd_valid && !rd_spec && (rd_a_poison || rd_b_poison);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '0) |-> (rd_a_data == '0 && !rd_a_poison && !rd_a_spec)); // R2

    AST_SPEC_FATAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_exc[1] && wr_spec && !rd_raise) |=> !exc_req); // R4

    AST_RESUME_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_exc == 2'd1) |=> (exc_req && exc_cause == 2'd1 && exc_reg == $past(wr_idx))); // R5

    AST_FATAL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_exc[1] && !wr_spec) |=> (exc_req && exc_cause == 2'd2)); // R6

    AST_POISON_USE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_raise && !wr_raise) |=> (exc_req && exc_cause == 2'd3)); // R7

    AST_LOW_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_raise && rd_a_poison && rd_b_poison && !wr_raise)
        |=> (exc_reg == $past((rd_a_idx < rd_b_idx) ? rd_a_idx : rd_b_idx))); // R7

    AST_SPEC_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_spec && !wr_raise) |=> !exc_req); // R8

    AST_CTL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctl_op == 2'd1 && ctl_idx != '0) && rd_a_idx == $past(ctl_idx))
        |-> rd_a_poison); // R9

    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (exc_cause == 2'd0 && exc_reg == '0)); // R10

endmodule

bind poison_regfile poison_regfile_chk #(.NREGS(NREGS), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/poison_regfile_tb_top.sv
module poison_regfile_tb_top;

    localparam int NREGS  = 32;
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(NREGS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              rd_valid = 0, rd_spec = 0;
    logic [IDX_W-1:0]  rd_a_idx = '0, rd_b_idx = '0;
    logic [DATA_W-1:0] rd_a_data, rd_b_data;
    logic              rd_a_poison, rd_a_spec, rd_b_poison, rd_b_spec, src_poison;
    logic              wr_en = 0, wr_spec = 0, wr_src_poison = 0;
    logic [IDX_W-1:0]  wr_idx = '0, ctl_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        wr_exc = 0, ctl_op = 0;
    logic              exc_req;
    logic [1:0]        exc_cause;
    logic [IDX_W-1:0]  exc_reg;

    poison_regfile #(.NREGS(NREGS), .DATA_W(DATA_W)) dut_i (.*);

    int checks = 0, errors = 0;
    logic [DATA_W-1:0] m_data [NREGS];
    logic              m_poi  [NREGS];
    logic              m_spec [NREGS];
    logic              e_req;
    logic [1:0]        e_cause;
    logic [IDX_W-1:0]  e_reg;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_fatal(input logic [1:0] c);
        return c[1];
    endfunction

    task automatic idle_inputs();
        rd_valid = 0; rd_spec = 0; wr_en = 0; wr_spec = 0; wr_exc = 0;
        wr_src_poison = 0; ctl_op = 0;
    endtask

    // inputs already driven after a falling edge; runs one clock
    task automatic run_cycle();
        logic wr_raise, rd_raise, pa, pb;
        string rt;
        #2;
        pa = m_poi[rd_a_idx];
        pb = m_poi[rd_b_idx];
        rt = (rd_a_idx == 0) ? "R2" : "R3";
        chk(rd_a_data == m_data[rd_a_idx], rt, "port A data", rd_a_data, m_data[rd_a_idx]);
        chk(rd_a_poison == pa, rt, "port A poison", rd_a_poison, pa);
        chk(rd_a_spec == m_spec[rd_a_idx], rt, "port A spec", rd_a_spec, m_spec[rd_a_idx]);
        chk(rd_b_data == m_data[rd_b_idx], "R3", "port B data", rd_b_data, m_data[rd_b_idx]);
        chk(rd_b_poison == pb, "R3", "port B poison", rd_b_poison, pb);
        chk(src_poison == (pa | pb), "R8", "src_poison", src_poison, pa | pb);
        // expected exception (R5, R6, R7, R10)
        wr_raise = wr_en && (wr_exc == 2'd1 || (is_fatal(wr_exc) && !wr_spec));
        rd_raise = rd_valid && !rd_spec && (pa || pb);
        e_req = wr_raise || rd_raise; e_cause = 0; e_reg = '0;
        if (wr_raise) begin
            e_cause = (wr_exc == 2'd1) ? 2'd1 : 2'd2;
            e_reg = wr_idx;
        end else if (rd_raise) begin
            e_cause = 2'd3;
            if (pa && pb) e_reg = (rd_a_idx < rd_b_idx) ? rd_a_idx : rd_b_idx;
            else          e_reg = pa ? rd_a_idx : rd_b_idx;
        end
        // model update
        if (wr_en && !wr_raise && wr_idx != 0) begin
            m_data[wr_idx] = wr_data;
            m_spec[wr_idx] = wr_spec;
            m_poi[wr_idx]  = wr_spec && (is_fatal(wr_exc) || wr_src_poison);
        end
        if (ctl_idx != 0 && ctl_op == 2'd1) m_poi[ctl_idx] = 1'b1;
        if (ctl_idx != 0 && ctl_op == 2'd2) m_poi[ctl_idx] = 1'b0;
        @(negedge clk);
        rt = !e_req ? "R10" : (e_cause == 2'd1) ? "R5" : (e_cause == 2'd2) ? "R6" : "R7";
        chk(exc_req == e_req, rt, "exc_req", exc_req, e_req);
        chk(exc_cause == e_cause, rt, "exc_cause", exc_cause, e_cause);
        chk(exc_reg == e_reg, rt, "exc_reg", exc_reg, e_reg);
    endtask

    task automatic do_write(input int idx, input logic [DATA_W-1:0] d, input bit sp,
                            input logic [1:0] ex, input bit sp_src);
        idle_inputs();
        wr_en = 1; wr_idx = IDX_W'(idx); wr_data = d; wr_spec = sp; wr_exc = ex;
        wr_src_poison = sp_src;
        run_cycle();
    endtask

    task automatic do_read(input int a, input int b, input bit v, input bit sp);
        idle_inputs();
        rd_valid = v; rd_spec = sp; rd_a_idx = IDX_W'(a); rd_b_idx = IDX_W'(b);
        run_cycle();
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < NREGS; r++) begin
            m_data[r] = '0; m_poi[r] = 0; m_spec[r] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of every entry
        for (int r = 0; r < NREGS; r++) begin
            rd_a_idx = IDX_W'(r); #1;
            chk(rd_a_data == 0 && !rd_a_poison && !rd_a_spec, "R1", "reset entry",
                {rd_a_poison, rd_a_spec}, 0);
        end
        chk(!exc_req, "R1", "reset exc_req", exc_req, 0);
        @(negedge clk);

        // R3 clean writes, spec and non-spec
        do_write(5, 32'hA5A5_0005, 0, 2'd0, 0);
        do_write(6, 32'h0000_0066, 1, 2'd0, 0);
        do_read(5, 6, 1, 0);
        // R4 speculative fatal write poisons silently, code 3 too
        do_write(9, 32'h99, 1, 2'd2, 0);
        do_write(12, 32'hC, 1, 2'd3, 0);
        do_read(9, 12, 1, 1);               // R8 speculative consumer: no fault
        // R8 propagation into a speculative destination
        do_write(14, 32'hE, 1, 2'd0, 1);
        do_read(14, 0, 1, 1);
        // R7 double poison, higher number on port A, then on port B
        do_read(12, 9, 1, 0);
        do_read(9, 14, 1, 0);
        do_read(0, 12, 1, 0);
        // R5 resumable, spec and non-spec; register untouched
        do_write(5, 32'hDEAD, 1, 2'd1, 0);
        do_write(5, 32'hBEEF, 0, 2'd1, 0);
        do_read(5, 5, 0, 0);
        // R6 non-spec fatal: raised, register untouched
        do_write(6, 32'h1234, 0, 2'd2, 0);
        do_read(6, 6, 0, 0);
        // R10 priority: resumable write with double-poisoned read
        idle_inputs();
        rd_valid = 1; rd_a_idx = 5'd12; rd_b_idx = 5'd9;
        wr_en = 1; wr_idx = 5'd3; wr_exc = 2'd1; wr_data = 32'h3;
        run_cycle();
        // R2 register 0 ignores writes and control
        do_write(0, 32'hFFFF_FFFF, 1, 2'd2, 1);
        idle_inputs(); ctl_op = 2'd1; ctl_idx = '0; run_cycle();
        do_read(0, 0, 1, 0);
        // R9 control set / clear, override of a same-cycle write
        idle_inputs(); ctl_op = 2'd1; ctl_idx = 5'd5; run_cycle();
        do_read(5, 6, 0, 0);
        idle_inputs(); ctl_op = 2'd2; ctl_idx = 5'd9; run_cycle();
        idle_inputs(); ctl_op = 2'd3; ctl_idx = 5'd12; run_cycle();
        idle_inputs();
        wr_en = 1; wr_idx = 5'd20; wr_spec = 1; wr_exc = 2'd2; wr_data = 32'h20;
        ctl_op = 2'd2; ctl_idx = 5'd20;
        run_cycle();
        do_read(20, 9, 1, 0);

        // constrained random traffic on a small register window
        for (int i = 0; i < 3000; i++) begin
            int k;
            idle_inputs();
            rd_valid = ($urandom % 4) != 0;
            rd_spec  = $urandom % 2;
            rd_a_idx = IDX_W'($urandom % 8);
            rd_b_idx = IDX_W'($urandom % 8);
            wr_en = ($urandom % 3) != 0;
            wr_idx = IDX_W'($urandom % 8);
            wr_data = $urandom;
            wr_spec = $urandom % 2;
            k = $urandom % 10;
            wr_exc = (k < 6) ? 2'd0 : (k < 7) ? 2'd1 : (k < 9) ? 2'd2 : 2'd3;
            wr_src_poison = $urandom % 2;
            if (($urandom % 6) == 0) begin
                ctl_op = 2'($urandom % 4);
                ctl_idx = IDX_W'($urandom % 8);
            end
            run_cycle();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule